// File: doc/BRIEF.md
# Bus Access Error Response Checker

This block is the device-side front end of a TL-UL style request/response port. Each request on the A channel is decoded against a fixed address map. The map holds a small set of CSR words and a set of memory windows. The block classifies whether the access is illegal and forwards legal accesses to downstream storage as one read or write strobe. It then returns the D-channel response from a one-deep response register, with the error flag and the returned data.

Each memory window has an access kind (read-write, read-only or write-only), a partial-write capability and a tolerance flag. For a read-only window the tolerance flag lets writes pass silently, and for a write-only window it lets reads pass silently. Each CSR has a register width, given as its most significant bit position, and a flag that allows sub-word writes. An interface-wide parameter can forbid byte enables everywhere. A run-time gate input can lock out every memory window.

The default map has these entries:
- CSR0 at 0x000, top bit 31.
- CSR1 at 0x004, top bit 20.
- CSR2 at 0x008, top bit 12.
- CSR3 at 0x00C, top bit 5.
- CSR4 at 0x010, top bit 31, sub-word writes allowed.
- Window W0 at 0x100–0x1FF, read-write, no partial writes.
- Window W1 at 0x200–0x2FF, read-only, partial writes allowed, not tolerant.
- Window W2 at 0x300–0x37F, write-only, partial writes allowed, reads tolerated.
- Window W3 at 0x380–0x3FF, write-only, partial writes allowed, not tolerant.

CSRs match on the word address, so address bits [1:0] are ignored.

Top module: `busreq_guard`

## Requirements
- R1: An address that hits no CSR word and no window sets d_error and produces no downstream strobe.
- R2: On a window without partial-write support, a Put (opcode 0 or 1) whose size is not 2 or whose mask is not 4'hF sets d_error.
- R3: A Get (opcode 4) to a write-only window sets d_error, unless the window tolerates reads. A tolerated read returns no error and data 0, and issues no read strobe.
- R4: Any non-Get opcode to a read-only window sets d_error, unless the window tolerates writes. A tolerated write returns no error and issues no write strobe.
- R5: A Put to a CSR sets d_error if any of these holds: the top bit is 24 or above and mask[3:0] is not 1111; the top bit is 16 or above and mask[2:0] is not 111; the top bit is 8 or above and mask[1:0] is not 11; mask[0] is 0.
- R6: The CSR width check of R5 does not apply to CSRs flagged for sub-word writes, to memory windows, or to unmapped addresses.
- R7: A Get answered with d_error returns d_data = 32'hFFFF_FFFF. Every Put response carries d_data = 0.
- R8: While mem_gate_i is 1, every access inside a window sets d_error. CSR accesses are not affected.
- R9: With parameter NO_BYTE_EN = 1, any Put whose size is not 2 or whose mask is not 4'hF sets d_error at every address.
- R10: A Get is answered with d_opcode 1 (AccessAckData) and every other opcode with d_opcode 0 (AccessAck). a_source and a_size are echoed. Opcodes other than 0, 1 and 4 set d_error.
- R11: A legal access raises exactly one of dn_we_o or dn_re_o in its accept cycle, with the address, data and mask of the request. A legal read returns dn_rdata_i from that cycle. An access with d_error raises neither strobe.
- R12: Only one response is held at a time. a_ready_o is low while d_valid_o is 1 and d_ready_i is 0, and a held response stays stable. A synchronous reset clears d_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mem_gate_i | input | 1 | Locks out all memory windows when 1 |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Request can be accepted |
| a_opcode_i | input | 3 | Request opcode (0 PutFull, 1 PutPartial, 4 Get) |
| a_address_i | input | AW | Byte address |
| a_size_i | input | 2 | Log2 of the access size in bytes |
| a_mask_i | input | 4 | Byte enables |
| a_source_i | input | SW | Requester tag |
| a_data_i | input | 32 | Write data |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Response taken |
| d_opcode_o | output | 3 | Response opcode |
| d_error_o | output | 1 | Access error flag |
| d_data_o | output | 32 | Read data |
| d_source_o | output | SW | Echoed requester tag |
| d_size_o | output | 2 | Echoed size |
| dn_we_o | output | 1 | Downstream write strobe |
| dn_re_o | output | 1 | Downstream read strobe |
| dn_mem_sel_o | output | 1 | Strobe targets a window (1) or a CSR (0) |
| dn_addr_o | output | AW | Downstream byte address |
| dn_wdata_o | output | 32 | Downstream write data |
| dn_mask_o | output | 4 | Downstream byte enables |
| dn_rdata_i | input | 32 | Downstream read data, valid in the strobe cycle |

## Verification
The assertions assume that the CSR words and windows in the parameters do not overlap, so at most one region is hit. They also assume dn_rdata_i is valid in the same cycle as dn_re_o. The bench keeps a_size_i at 2 or below and uses the default, non-overlapping map. It drives dn_rdata_i as a combinational function of dn_addr_o, so read data is always present in the strobe cycle. While a response is held, the bench only presents a new request to show that the request is refused, and it takes each response with d_ready_i high in the following cycle.

// File: rtl/busreq_pkg.sv
package busreq_pkg;

  localparam int DW = 32;
  localparam int MW = DW / 8;

  localparam logic [2:0] OP_PUT_FULL = 3'd0;
  localparam logic [2:0] OP_PUT_PART = 3'd1;
  localparam logic [2:0] OP_GET      = 3'd4;
  localparam logic [2:0] RSP_ACK      = 3'd0;
  localparam logic [2:0] RSP_ACK_DATA = 3'd1;

  localparam logic [1:0] ACC_RW = 2'd0;
  localparam logic [1:0] ACC_RO = 2'd1;
  localparam logic [1:0] ACC_WO = 2'd2;

  typedef struct packed {
    logic bad_op;
    logic unmapped;
    logic no_byte_en;
    logic gated;
    logic partial;
    logic wo_read;
    logic ro_write;
    logic csr_size;
  } err_flags_t;

  function automatic logic full_word(logic [1:0] size, logic [MW-1:0] mask);
    return (size == 2'd2) && (mask == {MW{1'b1}});
  endfunction

  function automatic logic csr_mask_ok(logic [4:0] msb, logic [MW-1:0] m);
    logic bad;
    bad = !m[0];
    if (msb >= 5'd8  && m[1:0] != 2'b11)  bad = 1'b1;
    if (msb >= 5'd16 && m[2:0] != 3'b111) bad = 1'b1;
    if (msb >= 5'd24 && m[3:0] != 4'hF)   bad = 1'b1;
    return !bad;
  endfunction

  function automatic logic [DW-1:0] rsp_data(logic get, logic err, logic blocked,
                                             logic [DW-1:0] rdata);
    if (!get)    return '0;
    if (err)     return '1;
    if (blocked) return '0;
    return rdata;
  endfunction

endpackage

// File: rtl/busreq_decode.sv
module busreq_decode #(
  parameter int AW   = 10,
  parameter int NCSR = 5,
  parameter int NWIN = 4,
  parameter logic [NCSR-1:0][AW-1:0] CSR_ADDR  = '0,
  parameter logic [NWIN-1:0][AW-1:0] WIN_BASE  = '0,
  parameter logic [NWIN-1:0][AW-1:0] WIN_WORDS = '0
) (
  input  logic [AW-1:0]   addr_i,
  output logic [NCSR-1:0] csr_hit_o,
  output logic [NWIN-1:0] win_hit_o
);

  logic [AW+1:0] addr_ext;
  assign addr_ext = {2'b00, addr_i};

  for (genvar c = 0; c < NCSR; c++) begin : g_csr
    assign csr_hit_o[c] = (addr_i[AW-1:2] == CSR_ADDR[c][AW-1:2]);
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [AW+1:0] LO = {2'b00, WIN_BASE[w]};
    localparam logic [AW+1:0] HI = LO + {WIN_WORDS[w], 2'b00};
    assign win_hit_o[w] = (addr_ext >= LO) && (addr_ext < HI);
  end

endmodule

// File: rtl/busreq_classify.sv
module busreq_classify
  import busreq_pkg::*;
#(
  parameter int NCSR = 5,
  parameter int NWIN = 4,
  parameter logic [NCSR-1:0][4:0] CSR_MSB   = '0,
  parameter logic [NCSR-1:0]      CSR_SUBOK = '0,
  parameter logic [NWIN-1:0][1:0] WIN_ACC   = '0,
  parameter logic [NWIN-1:0]      WIN_PART  = '0,
  parameter logic [NWIN-1:0]      WIN_TOL   = '0,
  parameter bit                   NO_BYTE_EN = 1'b0
) (
  input  logic [NCSR-1:0] csr_hit_i,
  input  logic [NWIN-1:0] win_hit_i,
  input  logic [2:0]      opcode_i,
  input  logic [1:0]      size_i,
  input  logic [MW-1:0]   mask_i,
  input  logic            mem_gate_i,
  output err_flags_t      flags_o,
  output logic            err_o,
  output logic            block_o,
  output logic            is_get_o,
  output logic            is_put_o,
  output logic            in_mem_o
);

  logic [4:0] msb_sel;
  logic       subok_sel, part_sel, tol_sel, in_csr, full;
  logic [1:0] acc_sel;
  logic       tolerated;

  always_comb begin
    msb_sel   = '0;
    subok_sel = 1'b0;
    for (int c = 0; c < NCSR; c++) begin
      if (csr_hit_i[c]) begin
        msb_sel   = msb_sel | CSR_MSB[c];
        subok_sel = subok_sel | CSR_SUBOK[c];
      end
    end
  end

  always_comb begin
    acc_sel  = '0;
    part_sel = 1'b0;
    tol_sel  = 1'b0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_hit_i[w]) begin
        acc_sel  = acc_sel | WIN_ACC[w];
        part_sel = part_sel | WIN_PART[w];
        tol_sel  = tol_sel | WIN_TOL[w];
      end
    end
  end

  assign in_csr   = |csr_hit_i;
  assign in_mem_o = |win_hit_i;
  assign is_get_o = (opcode_i == OP_GET);
  assign is_put_o = (opcode_i == OP_PUT_FULL) || (opcode_i == OP_PUT_PART);
  assign full     = full_word(size_i, mask_i);

  always_comb begin
    flags_o            = '0;
    flags_o.bad_op     = !is_get_o && !is_put_o;
    flags_o.unmapped   = !in_csr && !in_mem_o;
    flags_o.no_byte_en = NO_BYTE_EN && is_put_o && !full;
    flags_o.gated      = in_mem_o && mem_gate_i;
    flags_o.partial    = in_mem_o && !part_sel && is_put_o && !full;
    flags_o.wo_read    = in_mem_o && (acc_sel == ACC_WO) && is_get_o && !tol_sel;
    flags_o.ro_write   = in_mem_o && (acc_sel == ACC_RO) && !is_get_o && !tol_sel;
    flags_o.csr_size   = in_csr && !subok_sel && is_put_o && !csr_mask_ok(msb_sel, mask_i);
  end

  assign tolerated = in_mem_o && tol_sel &&
                     (((acc_sel == ACC_WO) && is_get_o) || ((acc_sel == ACC_RO) && !is_get_o));
  assign err_o   = |flags_o;
  assign block_o = err_o || tolerated;

endmodule

// File: rtl/busreq_rsp.sv
module busreq_rsp
  import busreq_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          accept_i,
  input  logic          is_get_i,
  input  logic          err_i,
  input  logic          block_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [SW-1:0] source_i,
  input  logic [1:0]    size_i,
  input  logic          d_ready_i,
  output logic          d_valid_o,
  output logic [2:0]    d_opcode_o,
  output logic          d_error_o,
  output logic [DW-1:0] d_data_o,
  output logic [SW-1:0] d_source_o,
  output logic [1:0]    d_size_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      d_valid_o  <= 1'b0;
      d_opcode_o <= RSP_ACK;
      d_error_o  <= 1'b0;
      d_data_o   <= '0;
      d_source_o <= '0;
      d_size_o   <= '0;
    end else if (accept_i) begin
      d_valid_o  <= 1'b1;
      d_opcode_o <= is_get_i ? RSP_ACK_DATA : RSP_ACK;
      d_error_o  <= err_i;
      d_data_o   <= rsp_data(is_get_i, err_i, block_i, rdata_i);
      d_source_o <= source_i;
      d_size_o   <= size_i;
    end else if (d_ready_i) begin
      d_valid_o  <= 1'b0;
    end
  end

  p_hold_stable_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    d_valid_o && !d_ready_i |=> d_valid_o && $stable(d_data_o) && $stable(d_error_o)
                                && $stable(d_source_o) && $stable(d_opcode_o));

  p_err_read_ones_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    d_valid_o && d_error_o && (d_opcode_o == RSP_ACK_DATA) |-> d_data_o == '1);

  p_put_zero_data_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    d_valid_o && (d_opcode_o == RSP_ACK) |-> d_data_o == '0);

endmodule

// File: rtl/busreq_guard.sv
module busreq_guard
  import busreq_pkg::*;
#(
  parameter int AW   = 10,
  parameter int SW   = 8,
  parameter int NCSR = 5,
  parameter int NWIN = 4,
  parameter logic [NCSR-1:0][AW-1:0] CSR_ADDR  = {10'h010, 10'h00C, 10'h008, 10'h004, 10'h000},
  parameter logic [NCSR-1:0][4:0]    CSR_MSB   = {5'd31, 5'd5, 5'd12, 5'd20, 5'd31},
  parameter logic [NCSR-1:0]         CSR_SUBOK = 5'b10000,
  parameter logic [NWIN-1:0][AW-1:0] WIN_BASE  = {10'h380, 10'h300, 10'h200, 10'h100},
  parameter logic [NWIN-1:0][AW-1:0] WIN_WORDS = {10'd32, 10'd32, 10'd64, 10'd64},
  parameter logic [NWIN-1:0][1:0]    WIN_ACC   = {2'd2, 2'd2, 2'd1, 2'd0},
  parameter logic [NWIN-1:0]         WIN_PART  = 4'b1110,
  parameter logic [NWIN-1:0]         WIN_TOL   = 4'b0100,
  parameter bit                      NO_BYTE_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          mem_gate_i,
  input  logic          a_valid_i,
  output logic          a_ready_o,
  input  logic [2:0]    a_opcode_i,
  input  logic [AW-1:0] a_address_i,
  input  logic [1:0]    a_size_i,
  input  logic [3:0]    a_mask_i,
  input  logic [SW-1:0] a_source_i,
  input  logic [31:0]   a_data_i,
  output logic          d_valid_o,
  input  logic          d_ready_i,
  output logic [2:0]    d_opcode_o,
  output logic          d_error_o,
  output logic [31:0]   d_data_o,
  output logic [SW-1:0] d_source_o,
  output logic [1:0]    d_size_o,
  output logic          dn_we_o,
  output logic          dn_re_o,
  output logic          dn_mem_sel_o,
  output logic [AW-1:0] dn_addr_o,
  output logic [31:0]   dn_wdata_o,
  output logic [3:0]    dn_mask_o,
  input  logic [31:0]   dn_rdata_i
);

  logic [NCSR-1:0] csr_hit;
  logic [NWIN-1:0] win_hit;
  err_flags_t      flags;
  logic            acc_err, acc_block, is_get, is_put, in_mem, accept;

  busreq_decode #(
    .AW(AW), .NCSR(NCSR), .NWIN(NWIN),
    .CSR_ADDR(CSR_ADDR), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)
  ) i_decode (
    .addr_i   (a_address_i),
    .csr_hit_o(csr_hit),
    .win_hit_o(win_hit)
  );

  busreq_classify #(
    .NCSR(NCSR), .NWIN(NWIN), .CSR_MSB(CSR_MSB), .CSR_SUBOK(CSR_SUBOK),
    .WIN_ACC(WIN_ACC), .WIN_PART(WIN_PART), .WIN_TOL(WIN_TOL), .NO_BYTE_EN(NO_BYTE_EN)
  ) i_classify (
    .csr_hit_i (csr_hit),
    .win_hit_i (win_hit),
    .opcode_i  (a_opcode_i),
    .size_i    (a_size_i),
    .mask_i    (a_mask_i),
    .mem_gate_i(mem_gate_i),
    .flags_o   (flags),
    .err_o     (acc_err),
    .block_o   (acc_block),
    .is_get_o  (is_get),
    .is_put_o  (is_put),
    .in_mem_o  (in_mem)
  );

  assign a_ready_o = !d_valid_o || d_ready_i;
  assign accept    = a_valid_i && a_ready_o;

  assign dn_we_o      = accept && is_put && !acc_block;
  assign dn_re_o      = accept && is_get && !acc_block;
  assign dn_mem_sel_o = in_mem;
  assign dn_addr_o    = a_address_i;
  assign dn_wdata_o   = a_data_i;
  assign dn_mask_o    = a_mask_i;

  busreq_rsp #(.SW(SW)) i_rsp (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .accept_i  (accept),
    .is_get_i  (is_get),
    .err_i     (acc_err),
    .block_i   (acc_block),
    .rdata_i   (dn_rdata_i),
    .source_i  (a_source_i),
    .size_i    (a_size_i),
    .d_ready_i (d_ready_i),
    .d_valid_o (d_valid_o),
    .d_opcode_o(d_opcode_o),
    .d_error_o (d_error_o),
    .d_data_o  (d_data_o),
    .d_source_o(d_source_o),
    .d_size_o  (d_size_o)
  );

  p_single_region_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0({csr_hit, win_hit}));

  p_unmapped_err_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    accept && flags.unmapped |=> d_valid_o && d_error_o);

  p_no_strobe_on_err_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (dn_we_o || dn_re_o) |-> !acc_err);

  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !(dn_we_o && dn_re_o));

  p_gate_err_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    accept && in_mem && mem_gate_i |=> d_error_o);

  p_backpressure_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    d_valid_o && !d_ready_i |-> !a_ready_o);

endmodule

// File: tb/test_busreq_guard.sv
module test_busreq_guard;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        gate = 1'b0;
  logic        a_valid = 1'b0;
  logic [2:0]  a_op = 3'd4;
  logic [9:0]  a_addr = '0;
  logic [1:0]  a_size = 2'd2;
  logic [3:0]  a_mask = 4'hF;
  logic [7:0]  a_src = '0;
  logic [31:0] a_data = '0;
  logic        d_ready = 1'b1;

  logic        a_rdy [2];
  logic        d_val [2];
  logic [2:0]  d_op  [2];
  logic        d_err [2];
  logic [31:0] d_dat [2];
  logic [7:0]  d_src [2];
  logic [1:0]  d_sz  [2];
  logic        we [2], re [2], msel [2];
  logic [9:0]  dn_addr [2];
  logic [31:0] dn_wd [2], dn_rd [2];
  logic [3:0]  dn_mk [2];

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  for (genvar k = 0; k < 2; k++) begin : g_dut
    assign dn_rd[k] = 32'hC0DE_0000 | {22'b0, dn_addr[k]};
  end

  busreq_guard i_busreq_guard (
    .clk_i(clk), .rst_i(rst), .mem_gate_i(gate),
    .a_valid_i(a_valid), .a_ready_o(a_rdy[0]), .a_opcode_i(a_op), .a_address_i(a_addr),
    .a_size_i(a_size), .a_mask_i(a_mask), .a_source_i(a_src), .a_data_i(a_data),
    .d_valid_o(d_val[0]), .d_ready_i(d_ready), .d_opcode_o(d_op[0]), .d_error_o(d_err[0]),
    .d_data_o(d_dat[0]), .d_source_o(d_src[0]), .d_size_o(d_sz[0]),
    .dn_we_o(we[0]), .dn_re_o(re[0]), .dn_mem_sel_o(msel[0]), .dn_addr_o(dn_addr[0]),
    .dn_wdata_o(dn_wd[0]), .dn_mask_o(dn_mk[0]), .dn_rdata_i(dn_rd[0])
  );

  busreq_guard #(.NO_BYTE_EN(1'b1)) i_busreq_guard_nbe (
    .clk_i(clk), .rst_i(rst), .mem_gate_i(gate),
    .a_valid_i(a_valid), .a_ready_o(a_rdy[1]), .a_opcode_i(a_op), .a_address_i(a_addr),
    .a_size_i(a_size), .a_mask_i(a_mask), .a_source_i(a_src), .a_data_i(a_data),
    .d_valid_o(d_val[1]), .d_ready_i(d_ready), .d_opcode_o(d_op[1]), .d_error_o(d_err[1]),
    .d_data_o(d_dat[1]), .d_source_o(d_src[1]), .d_size_o(d_sz[1]),
    .dn_we_o(we[1]), .dn_re_o(re[1]), .dn_mem_sel_o(msel[1]), .dn_addr_o(dn_addr[1]),
    .dn_wdata_o(dn_wd[1]), .dn_mask_o(dn_mk[1]), .dn_rdata_i(dn_rd[1])
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the default map and rules
  task automatic model(input logic [9:0] ad, input logic [2:0] op, input logic [1:0] sz,
                       input logic [3:0] mk, input logic gt, input bit nbe,
                       output logic err, output logic wr, output logic rd,
                       output logic [31:0] dat, output string tag);
    logic get, put, whole, csr, w0, w1, w2, w3, win, tol_hit;
    logic [3:0] need;
    int idx, msb;
    get = (op == 3'd4);
    put = (op <= 3'd1);
    whole = (sz == 2'd2) && (mk == 4'b1111);
    idx = int'(ad) / 4;
    csr = (idx < 5);
    w0 = ad >= 10'h100 && ad < 10'h200;
    w1 = ad >= 10'h200 && ad < 10'h300;
    w2 = ad >= 10'h300 && ad < 10'h380;
    w3 = ad >= 10'h380;
    win = w0 | w1 | w2 | w3;
    case (idx)
      0: msb = 31; 1: msb = 20; 2: msb = 12; 3: msb = 5; default: msb = 31;
    endcase
    need = (msb >= 24) ? 4'b1111 : (msb >= 16) ? 4'b0111 : (msb >= 8) ? 4'b0011 : 4'b0001;
    err = 1'b0; tag = "R11";
    if (csr && idx != 4 && put && ((mk & need) != need)) begin err = 1; tag = "R5"; end
    if (w1 && !get)                  begin err = 1; tag = "R4"; end
    if (w3 && get)                   begin err = 1; tag = "R3"; end
    if (w0 && put && !whole)         begin err = 1; tag = "R2"; end
    if (win && gt)                   begin err = 1; tag = "R8"; end
    if (nbe && put && !whole)        begin err = 1; tag = "R9"; end
    if (!csr && !win)                begin err = 1; tag = "R1"; end
    if (!get && !put)                begin err = 1; tag = "R10"; end
    tol_hit = w2 && get;
    if (!err && tol_hit) tag = "R3";
    if (!err && csr && idx == 4 && put) tag = "R6";
    wr = put && !err && !tol_hit;
    rd = get && !err && !tol_hit;
    dat = !get ? 32'h0 : err ? 32'hFFFF_FFFF : tol_hit ? 32'h0 : (32'hC0DE_0000 | {22'b0, ad});
  endtask

  logic [9:0] addrs [16] = '{10'h000, 10'h004, 10'h008, 10'h00E, 10'h010, 10'h014, 10'h0FC,
                             10'h100, 10'h1FC, 10'h200, 10'h2FC, 10'h300, 10'h37C, 10'h380,
                             10'h3FC, 10'h0A0};
  logic [2:0] ops [4] = '{3'd0, 3'd1, 3'd4, 3'd2};

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic e, w, r;
    logic [31:0] dx;
    logic s_we [2], s_re [2], s_ms [2];
    logic [9:0] s_ad [2];
    logic [31:0] s_wd [2];
    logic [3:0] s_mk [2];
    string tg;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset d_valid", {63'b0, d_val[0]}, 64'd0);
    check("R12 reset a_ready", {63'b0, a_rdy[0]}, 64'd1);

    for (int ai = 0; ai < 16; ai++)
      for (int oi = 0; oi < 4; oi++)
        for (int sz = 0; sz < 3; sz++)
          for (int mk = 0; mk < 16; mk++)
            for (int gt = 0; gt < 2; gt++) begin
              @(negedge clk);
              a_valid = 1'b1; a_addr = addrs[ai]; a_op = ops[oi]; a_size = sz[1:0];
              a_mask = mk[3:0]; gate = gt[0]; a_src = a_src + 8'd37;
              a_data = {a_src, ~a_src, 6'd0, a_addr};
              #1;
              for (int k = 0; k < 2; k++) begin
                s_we[k] = we[k]; s_re[k] = re[k]; s_ms[k] = msel[k];
                s_ad[k] = dn_addr[k]; s_wd[k] = dn_wd[k]; s_mk[k] = dn_mk[k];
              end
              @(negedge clk);
              for (int k = 0; k < 2; k++) begin
                model(a_addr, a_op, a_size, a_mask, gate, k == 1, e, w, r, dx, tg);
                check({tg, " strobes/response"},
                      {s_we[k], s_re[k], d_val[k], d_err[k], d_op[k], d_src[k], d_sz[k], dx},
                      {w, r, 1'b1, e, (a_op == 3'd4) ? 3'd1 : 3'd0, a_src, a_size, dx});
                check({tg, " data"}, {32'b0, d_dat[k]}, {32'b0, dx});
                if (w || r)
                  check("R11 downstream fields",
                        {s_ms[k], s_ad[k], s_mk[k], s_wd[k], 17'b0},
                        {a_addr >= 10'h100, a_addr, a_mask, a_data, 17'b0});
              end
              a_valid = 1'b0;
            end

    // Backpressure: hold a response, refuse a second request
    gate = 1'b0;
    @(negedge clk);
    d_ready = 1'b0; a_valid = 1'b1; a_op = 3'd4; a_addr = 10'h104; a_size = 2'd2;
    a_mask = 4'hF; a_src = 8'h5A;
    @(negedge clk);
    a_op = 3'd0; a_addr = 10'h108; a_src = 8'hA5;
    #1;
    check("R12 held a_ready low", {62'b0, d_val[0], a_rdy[0]}, {62'b0, 2'b10});
    check("R12 no strobe while held", {63'b0, we[0]}, 64'd0);
    @(negedge clk);
    check("R12 held response stable", {24'b0, d_src[0], d_dat[0]},
          {24'b0, 8'h5A, 32'hC0DE_0104});
    d_ready = 1'b1;
    #1;
    check("R12 accept after release", {62'b0, a_rdy[0], we[0]}, {62'b0, 2'b11});
    @(negedge clk);
    check("R12 next response", {53'b0, d_val[0], d_op[0], d_src[0]}, {53'b0, 1'b1, 3'd0, 8'hA5});
    a_valid = 1'b0;
    @(negedge clk);
    check("R12 response drained", {63'b0, d_val[0]}, 64'd0);

    // Synchronous reset clears a held response
    d_ready = 1'b0; a_valid = 1'b1; a_op = 3'd4; a_addr = 10'h000;
    @(negedge clk);
    a_valid = 1'b0;
    check("R12 response before reset", {63'b0, d_val[0]}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset clears response", {63'b0, d_val[0]}, 64'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule